// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between a CPU and its main memory and turns logical addresses that fall in the low RAM window into physical addresses. The window covers every address with bits [23:22] clear, which is everything below 0x400000. A page table of 1024 entries is held inside the block. Each entry is 16 bits and describes one 4 KB page. Addresses at or above 0x400000 leave the block unchanged.

Every access that lands on a present page also advances that page's two-bit usage state in the same clock edge. The state codes are: 0 for absent, 1 for present and untouched, 2 for read, and 3 for written. The update is a single-cycle read-modify-write. Software loads and inspects table entries through a 16-bit port. When that port writes the entry that an access is updating in the same cycle, the port write wins.

The translated result is registered and appears one clock after the access strobe. The result holds until the next strobe.

Top module: `page_xlat_unit`

## Requirements
- R1: An access whose address has bits [23:22] equal to zero is translated, and one cycle later `mapped_o` is 1. Any other address appears unchanged on `phys_addr_o` one cycle later, with `mapped_o` at 0.
- R2: The table index is address bits [21:12]. The translated address is {entry[9:0], address[11:0]}, zero-extended to 24 bits. The page state does not affect translation.
- R3: In a cycle without `acc_req_i`, `phys_addr_o` and `mapped_o` keep their values.
- R4: An access to an entry whose bits [14:13] equal 1 sets those bits to 2 for a read (`acc_wr_i`=0) or to 3 for a write.
- R5: On an entry in state 2 or 3, a write sets the state to 3 and a read leaves the state as it was.
- R6: An access to an entry in state 0 leaves the whole entry unchanged.
- R7: A state update never changes entry bit 15 (the write-enable flag) or bits [12:0].
- R8: A port write (`map_we_i`) stores `map_wdata_i` into entry `map_idx_i` at the clock edge. `map_rdata_o` shows entry `map_idx_i` combinationally.
- R9: If a port write and a state update target the same entry in one cycle, the entry ends up equal to the port data. The translation in that cycle uses the entry's value from before the edge.
- R10: After reset, every entry is 0, `phys_addr_o` is 0 and `mapped_o` is 0.
- R11: An access outside the translated window changes no entry, including the entry that its bits [21:12] would select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_req_i | input | 1 | Access strobe |
| acc_wr_i | input | 1 | Access is a write (1) or a read (0) |
| acc_addr_i | input | 24 | Logical address |
| map_we_i | input | 1 | Table entry write strobe |
| map_idx_i | input | 10 | Table entry index for the port |
| map_wdata_i | input | 16 | Table entry write data |
| map_rdata_o | output | 16 | Table entry at `map_idx_i` |
| phys_addr_o | output | 24 | Registered physical address |
| mapped_o | output | 1 | Registered: last access was translated |

## Verification
The assertions assume the following about the inputs:
- Every input is known (never X) and changes only away from the rising edge.
- Both strobes stay low while reset is asserted.
- The checks that compare an entry before and after an update rely on the same index being presented on two consecutive cycles. The stimulus provides this explicitly in the directed cases.

The bench drives all inputs on the falling edge and holds the strobes low during reset. Random accesses are confined to sixteen pages so that state transitions and same-entry collisions with port writes occur often. About one access in eight is aimed above the window, to exercise pass-through and aliasing.

// File: rtl/page_xlat_pkg.sv
package page_xlat_pkg;

  typedef enum logic [1:0] {
    PG_ABSENT = 2'd0,
    PG_FRESH  = 2'd1,
    PG_READ   = 2'd2,
    PG_DIRTY  = 2'd3
  } pg_state_e;

  // entry field positions decoded by software
  localparam int unsigned ST_LSB = 13;
  localparam int unsigned WE_BIT = 15;

  function automatic pg_state_e pg_next(pg_state_e cur, logic wr);
    pg_state_e nxt;
    unique case (cur)
      PG_ABSENT: nxt = PG_ABSENT;
      PG_FRESH:  nxt = wr ? PG_DIRTY : PG_READ;
      default:   nxt = wr ? PG_DIRTY : cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/page_xlat_decode.sv
module page_xlat_decode #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              in_win_o
);
  localparam int unsigned WIN_W = OFF_W + IDX_W;

  assign off_o    = addr_i[OFF_W-1:0];
  assign idx_o    = addr_i[WIN_W-1:OFF_W];
  assign in_win_o = (addr_i[ADDR_W-1:WIN_W] == '0);

endmodule

// File: rtl/page_xlat_status.sv
module page_xlat_status
  import page_xlat_pkg::*;
#(
  parameter int unsigned ENTRY_W = 16
) (
  input  logic [ENTRY_W-1:0] old_i,
  input  logic               wr_i,
  input  logic               hit_i,
  output logic [ENTRY_W-1:0] new_o,
  output logic               upd_o
);
  pg_state_e cur, nxt;

  always_comb begin
    cur   = pg_state_e'(old_i[ST_LSB+1:ST_LSB]);
    nxt   = pg_next(cur, wr_i);
    new_o = old_i;
    new_o[ST_LSB+1:ST_LSB] = nxt;
    upd_o = hit_i && (cur != PG_ABSENT);
  end

endmodule

// File: rtl/page_xlat_map.sv
module page_xlat_map
  import page_xlat_pkg::*;
#(
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned ENTRY_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               port_we_i,
  input  logic [IDX_W-1:0]   port_idx_i,
  input  logic [ENTRY_W-1:0] port_wdata_i,
  output logic [ENTRY_W-1:0] port_rdata_o,
  input  logic [IDX_W-1:0]   acc_idx_i,
  output logic [ENTRY_W-1:0] acc_entry_o,
  input  logic               upd_en_i,
  input  logic [ENTRY_W-1:0] upd_entry_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [ENTRY_W-1:0] ent_q [DEPTH];
  logic               clash;

  assign port_rdata_o = ent_q[port_idx_i];
  assign acc_entry_o  = ent_q[acc_idx_i];
  assign clash        = port_we_i && (port_idx_i == acc_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      if (upd_en_i && !clash) ent_q[acc_idx_i] <= upd_entry_i;
      if (port_we_i)          ent_q[port_idx_i] <= port_wdata_i;
    end
  end

  // R8 R9: port data lands, also over a same-entry update
  assert_port_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_we_i |=> ent_q[$past(port_idx_i)] == $past(port_wdata_i));

  // R7: write-enable and low fields survive a status update
  assert_keep_wen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !clash) |=>
      ent_q[$past(acc_idx_i)][WE_BIT] == $past(acc_entry_o[WE_BIT]));

  assert_keep_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !clash) |=>
      ent_q[$past(acc_idx_i)][ST_LSB-1:0] == $past(acc_entry_o[ST_LSB-1:0]));

endmodule

// File: rtl/page_xlat_outreg.sv
module page_xlat_outreg #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] phys_d_i,
  input  logic              mapped_d_i,
  output logic [ADDR_W-1:0] phys_q_o,
  output logic              mapped_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phys_q_o   <= '0;
      mapped_q_o <= 1'b0;
    end else if (load_i) begin
      phys_q_o   <= phys_d_i;
      mapped_q_o <= mapped_d_i;
    end
  end

  // R3: outputs hold without a strobe
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(phys_q_o) && $stable(mapped_q_o));

endmodule

// File: rtl/page_xlat_unit.sv
module page_xlat_unit
  import page_xlat_pkg::*;
#(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned PPN_W   = 10,
  parameter int unsigned ENTRY_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_req_i,
  input  logic               acc_wr_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic               map_we_i,
  input  logic [IDX_W-1:0]   map_idx_i,
  input  logic [ENTRY_W-1:0] map_wdata_i,
  output logic [ENTRY_W-1:0] map_rdata_o,
  output logic [ADDR_W-1:0]  phys_addr_o,
  output logic               mapped_o
);
  localparam int unsigned PHYS_W = PPN_W + OFF_W;

  logic [IDX_W-1:0]   acc_idx;
  logic [OFF_W-1:0]   acc_off;
  logic               in_win, hit;
  logic [ENTRY_W-1:0] acc_entry, upd_entry;
  logic               upd_en;
  logic [ADDR_W-1:0]  phys_d;
  logic [PHYS_W-1:0]  xlat;

  page_xlat_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dec (
    .addr_i(acc_addr_i), .idx_o(acc_idx), .off_o(acc_off), .in_win_o(in_win));

  assign hit = acc_req_i && in_win;

  page_xlat_status #(.ENTRY_W(ENTRY_W)) u_stat (
    .old_i(acc_entry), .wr_i(acc_wr_i), .hit_i(hit),
    .new_o(upd_entry), .upd_o(upd_en));

  page_xlat_map #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_map (
    .clk_i, .rst_ni,
    .port_we_i(map_we_i), .port_idx_i(map_idx_i), .port_wdata_i(map_wdata_i),
    .port_rdata_o(map_rdata_o),
    .acc_idx_i(acc_idx), .acc_entry_o(acc_entry),
    .upd_en_i(upd_en), .upd_entry_i(upd_entry));

  assign xlat   = {acc_entry[PPN_W-1:0], acc_off};
  assign phys_d = in_win ? ADDR_W'(xlat) : acc_addr_i;

  page_xlat_outreg #(.ADDR_W(ADDR_W)) u_out (
    .clk_i, .rst_ni, .load_i(acc_req_i), .phys_d_i(phys_d), .mapped_d_i(in_win),
    .phys_q_o(phys_addr_o), .mapped_q_o(mapped_o));

  logic       clash;
  logic [1:0] cur_st;
  assign clash  = map_we_i && (map_idx_i == acc_idx);
  assign cur_st = acc_entry[ST_LSB+1:ST_LSB];

  // R1: addresses above the window pass straight through
  assert_pass_thru_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_i && !in_win) |=> (phys_addr_o == $past(acc_addr_i)) && !mapped_o);

  // R5: a write to a present page leaves it dirty
  assert_dirty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_idx == $past(acc_idx)) &&
    $past(hit && acc_wr_i && (cur_st != 2'd0) && !clash)
      |-> acc_entry[ST_LSB+1:ST_LSB] == 2'd3);

  // R6: an absent page is not touched
  assert_absent_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_idx == $past(acc_idx)) && $past(hit && (cur_st == 2'd0) && !clash)
      |-> acc_entry == $past(acc_entry));

endmodule

// File: tb/page_xlat_unit_tb_top.sv
`timescale 1ns/1ps
module page_xlat_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_req = 1'b0, acc_wr = 1'b0;
  logic [23:0] acc_addr = '0;
  logic        map_we = 1'b0;
  logic [9:0]  map_idx = '0;
  logic [15:0] map_wdata = '0;
  logic [15:0] map_rdata;
  logic [23:0] phys;
  logic        mapped;

  always #2.5 clk = ~clk;

  page_xlat_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_req_i(acc_req), .acc_wr_i(acc_wr), .acc_addr_i(acc_addr),
    .map_we_i(map_we), .map_idx_i(map_idx), .map_wdata_i(map_wdata),
    .map_rdata_o(map_rdata), .phys_addr_o(phys), .mapped_o(mapped));

  int unsigned n_run = 0, n_fail = 0;
  logic [15:0] model [1024];
  logic [23:0] exp_phys = '0;
  logic        exp_map  = 1'b0;

  function automatic logic [15:0] next_ent(logic [15:0] old, logic wr);
    logic [1:0] s, ns;
    s = old[14:13];
    if (s == 2'd0) return old;
    ns = wr ? 2'd3 : ((s == 2'd1) ? 2'd2 : s);
    return {old[15], ns, old[12:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: inputs at falling edge, outputs checked after rising edge
  task automatic step(logic a_req, logic [23:0] a, logic w,
                      logic c_we, logic [9:0] ci, logic [15:0] cd, string tag);
    logic [9:0] idx;
    idx = a[21:12];
    acc_req = a_req; acc_addr = a; acc_wr = w;
    map_we = c_we; map_idx = ci; map_wdata = cd;
    if (a_req) begin
      if (a[23:22] == 2'b00) begin
        exp_phys = {2'b00, model[idx][9:0], a[11:0]};
        exp_map  = 1'b1;
        model[idx] = next_ent(model[idx], w);
      end else begin
        exp_phys = a;
        exp_map  = 1'b0;
      end
    end
    if (c_we) model[ci] = cd;
    @(posedge clk); #1;
    acc_req = 1'b0; map_we = 1'b0;
    chk({tag, " phys"}, 32'(phys), 32'(exp_phys));
    chk({tag, " mapped"}, 32'(mapped), 32'(exp_map));
  endtask

  task automatic chk_ent(logic [9:0] i, string tag);
    map_idx = i; #0.5;
    chk({tag, " entry"}, 32'(map_rdata), 32'(model[i]));
  endtask

  task automatic put(logic [9:0] i, logic [15:0] d, string tag);
    step(1'b0, 24'h0, 1'b0, 1'b1, i, d, tag);
    chk_ent(i, tag);
    @(negedge clk);
  endtask

  task automatic acc(logic [23:0] a, logic w, string tag);
    step(1'b1, a, w, 1'b0, 10'd0, 16'h0, tag);
    chk_ent(a[21:12], tag);
    @(negedge clk);
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 1024; i++) model[i] = '0;
    void'($urandom(32'd20111));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 phys", 32'(phys), 32'h0);
    chk("R10 mapped", 32'(mapped), 32'h0);
    chk_ent(10'd0, "R10");
    chk_ent(10'd1023, "R10");
    @(negedge clk);

    // R8 port write and readback
    put(10'd5, 16'hA123, "R8");           // WE=1, state 1, ppn 0x123
    // R1 R2 translated read, R4 state 1 -> 2
    acc(24'h005ABC, 1'b0, "R2");
    chk("R4 state", 32'(model[5][14:13]), 32'd2);
    chk("R7 wen", 32'(model[5][15]), 32'd1);
    // R5 write -> dirty, then read keeps dirty
    acc(24'h005001, 1'b1, "R5");
    acc(24'h005002, 1'b0, "R5");
    // R3 idle cycle holds outputs
    step(1'b0, 24'hFFFFFF, 1'b1, 1'b0, 10'd0, 16'h0, "R3");
    @(negedge clk);
    // R5 state 2 read stays 2
    put(10'd6, 16'h4044, "R5");
    acc(24'h006100, 1'b0, "R5");
    // R6 absent page unchanged but still translated
    put(10'd7, 16'h8055, "R6");
    acc(24'h007FFF, 1'b1, "R6");
    acc(24'h007000, 1'b0, "R6");
    // R7 write-enable clear survives a write update
    put(10'd8, 16'h3ABC, "R7");           // WE=0, state 1, low bits set
    acc(24'h008010, 1'b1, "R7");
    chk("R7 wen", 32'(model[8]), 32'h7ABC);
    // R11 out-of-window aliasing index 1
    put(10'd1, 16'h2011, "R11");
    acc(24'h401ABC, 1'b1, "R11");
    chk_ent(10'd1, "R11");
    acc(24'hFFFFFF, 1'b0, "R1");
    acc(24'h400000, 1'b0, "R1");
    // R1 upper boundary of window, index 1023
    put(10'd1023, 16'h23FF, "R1");
    acc(24'h3FFFFF, 1'b1, "R1");
    // R9 collision: port wins, translation uses old ppn
    put(10'd9, 16'h2033, "R9");
    step(1'b1, 24'h009444, 1'b1, 1'b1, 10'd9, 16'h2077, "R9");
    chk_ent(10'd9, "R9");
    @(negedge clk);
    acc(24'h009444, 1'b0, "R9");

    // random phase over 16 pages
    for (int i = 0; i < 16; i++) put(10'(i), 16'($urandom), "R8");
    for (int n = 0; n < 3000; n++) begin
      logic [23:0] a;
      logic        rq, w, cw;
      logic [9:0]  ci;
      a = 24'($urandom);
      a[21:16] = '0;
      if (($urandom % 8) == 0) a[23:22] = 2'(1 + $urandom % 3);
      else a[23:22] = 2'b00;
      rq = (($urandom % 6) != 0);
      w  = 1'($urandom);
      cw = (($urandom % 6) == 0);
      ci = 10'($urandom % 16);
      step(rq, a, w, cw, ci, 16'($urandom), "R4");
      chk_ent(a[21:12], "R4");
      chk_ent(ci, "R8");
      @(negedge clk);
    end
    finish_up();
  end
endmodule